// File: doc/BRIEF.md
# Real-Time-Clock Interrupt and Control Register Bank

This block holds the interrupt and control registers of a real-time-clock peripheral. It sits on a simple word bus that has a select, a write enable, a byte address, write data and combinational read data. Every access is one whole 32-bit little-endian word: bus bit 0 is register bit 0. The time counter, the alarm comparator and the calibration arithmetic live outside this block. The bank only stores their settings and passes the live counter values through for reading.

There are two interrupt groups. The clock group has two event inputs. The address-error group has one event input, and any bus access to an offset that is not mapped also raises its bit. Each group has a sticky status register that is cleared by writing ones, and a mask register that the bus cannot write. A write to an enable command offset clears mask bits, and a write to a disable command offset sets them. Each group drives a level interrupt that is high while any status bit is set and its mask bit is clear. Every mask comes out of reset fully set, so both interrupts start disabled.

Top module: `clk_irq_regbank`

Register offsets (byte address): 0x00 control, 0x04 clock status, 0x08 clock mask, 0x0C clock enable, 0x10 clock disable, 0x14 error status, 0x18 error mask, 0x1C error enable, 0x20 error disable, 0x24 set-time store, 0x28 set-time read-back, 0x2C calibration store, 0x30 calibration read-back, 0x34 current time, 0x38 current tick, 0x3C alarm store, 0x40 safety-check store.

## Requirements
- R1: After reset these reads hold: control = 0x01000000, clock mask = 0x3, error mask = 0x1, both status registers = 0. Both interrupt outputs are low.
- R2: A high level on evtClk[i] sets clock status bit i (offset 0x04) at the next clock edge. If an event and a write-one-to-clear hit the same bit in the same cycle, the bit ends up set.
- R3: Writing to offset 0x04 clears each clock status bit whose write-data bit is 1. Bits whose write-data bit is 0 keep their value.
- R4: The error status register (offset 0x14) is one bit, bit 0. evtErr sets it at the next edge, and writing a 1 to bit 0 clears it.
- R5: irqClk is high exactly when some clock status bit is 1 and its clock mask bit is 0. irqErr behaves the same way for the error group.
- R6: Bus writes to the mask offsets 0x08 and 0x18 change nothing.
- R7: A write to 0x0C (or 0x1C) clears the clock (or error) mask bits where the data has ones. A write to 0x10 (or 0x20) sets them. The four command offsets store nothing and read 0.
- R8: In the control register (offset 0x00) only bits 0x8f000001 are writable. The reserved bits 0x70fffffe always read 0 and ignore writes.
- R9: The set-time (0x24), alarm (0x3C) and safety-check (0x40) stores read back the last 32-bit value written. The calibration store (0x2C) keeps only the low 21 bits.
- R10: The read-back offsets 0x28 and 0x30 return the set-time and calibration stores. Writes to these offsets change nothing.
- R11: Offset 0x34 returns timeIn and offset 0x38 returns tickIn zero-extended from 16 bits. Writes to either offset are ignored.
- R12: An access to an offset above 0x40, or to an address whose two low bits are not 0, reads 0, stores nothing, and sets error status bit 0 at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Access valid this cycle |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data (combinational, 0 when no read is in progress) |
| evtClk | input | 2 | Clock-group event inputs |
| evtErr | input | 1 | Address-error event input |
| timeIn | input | 32 | Live seconds count from the external counter |
| tickIn | input | 16 | Live sub-second tick from the external counter |
| irqClk | output | 1 | Clock-group level interrupt |
| irqErr | output | 1 | Address-error level interrupt |

## Verification
A behavioural model in the bench follows every edge and is compared with both interrupt lines on every cycle and with each read. Events are first raised while the mask is fully set, which separates the status from the interrupt. They are then unmasked one bit at a time through the enable and disable commands, which shows that the two mask bits are independent. Clear writes are tried with a zero bit, a one bit, and at the same time as an event on that bit, which separates plain write-one-to-clear from set-wins. Misaligned and out-of-range accesses, together with all-ones writes to the control, mask and read-only offsets, show which bits can really be written.

// File: rtl/clk_irq_pkg.sv
`timescale 1ns/1ps
package clk_irq_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFF_CTRL   = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_CSTAT  = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_CMASK  = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_CEN    = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_CDIS   = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_ESTAT  = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_EMASK  = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_EEN    = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_EDIS   = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_SETT   = 8'h24;
  localparam logic [ADDR_W-1:0] OFF_SETTRB = 8'h28;
  localparam logic [ADDR_W-1:0] OFF_CAL    = 8'h2C;
  localparam logic [ADDR_W-1:0] OFF_CALRB  = 8'h30;
  localparam logic [ADDR_W-1:0] OFF_TIME   = 8'h34;
  localparam logic [ADDR_W-1:0] OFF_TICK   = 8'h38;
  localparam logic [ADDR_W-1:0] OFF_ALARM  = 8'h3C;
  localparam logic [ADDR_W-1:0] OFF_SAFE   = 8'h40;

  typedef enum logic [4:0] {
    SEL_NONE, SEL_CTRL, SEL_CSTAT, SEL_CMASK, SEL_CEN, SEL_CDIS,
    SEL_ESTAT, SEL_EMASK, SEL_EEN, SEL_EDIS, SEL_SETT, SEL_SETTRB,
    SEL_CAL, SEL_CALRB, SEL_TIME, SEL_TICK, SEL_ALARM, SEL_SAFE
  } regSel_e;

  typedef struct packed {
    logic wrCtrl;
    logic w1cClk;
    logic enClk;
    logic disClk;
    logic w1cErr;
    logic enErr;
    logic disErr;
    logic wrSetT;
    logic wrCal;
    logic wrAlarm;
    logic wrSafe;
    logic badAcc;
  } strobe_t;
endpackage

// File: rtl/clk_irq_ctrl.sv
`timescale 1ns/1ps
module clk_irq_ctrl
  import clk_irq_pkg::*;
(
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           stb,
  output regSel_e           rdSel
);
  regSel_e hitSel;

  always_comb begin
    case (busAddr)
      OFF_CTRL:   hitSel = SEL_CTRL;
      OFF_CSTAT:  hitSel = SEL_CSTAT;
      OFF_CMASK:  hitSel = SEL_CMASK;
      OFF_CEN:    hitSel = SEL_CEN;
      OFF_CDIS:   hitSel = SEL_CDIS;
      OFF_ESTAT:  hitSel = SEL_ESTAT;
      OFF_EMASK:  hitSel = SEL_EMASK;
      OFF_EEN:    hitSel = SEL_EEN;
      OFF_EDIS:   hitSel = SEL_EDIS;
      OFF_SETT:   hitSel = SEL_SETT;
      OFF_SETTRB: hitSel = SEL_SETTRB;
      OFF_CAL:    hitSel = SEL_CAL;
      OFF_CALRB:  hitSel = SEL_CALRB;
      OFF_TIME:   hitSel = SEL_TIME;
      OFF_TICK:   hitSel = SEL_TICK;
      OFF_ALARM:  hitSel = SEL_ALARM;
      OFF_SAFE:   hitSel = SEL_SAFE;
      default:    hitSel = SEL_NONE;
    endcase
  end

  always_comb begin
    stb = '0;
    if (busSel) begin
      if (hitSel == SEL_NONE) stb.badAcc = 1'b1;
      else if (busWe) begin
        case (hitSel)
          SEL_CTRL:  stb.wrCtrl  = 1'b1;
          SEL_CSTAT: stb.w1cClk  = 1'b1;
          SEL_CEN:   stb.enClk   = 1'b1;
          SEL_CDIS:  stb.disClk  = 1'b1;
          SEL_ESTAT: stb.w1cErr  = 1'b1;
          SEL_EEN:   stb.enErr   = 1'b1;
          SEL_EDIS:  stb.disErr  = 1'b1;
          SEL_SETT:  stb.wrSetT  = 1'b1;
          SEL_CAL:   stb.wrCal   = 1'b1;
          SEL_ALARM: stb.wrAlarm = 1'b1;
          SEL_SAFE:  stb.wrSafe  = 1'b1;
          default:   ;
        endcase
      end
    end
  end

  assign rdSel = (busSel && !busWe) ? hitSel : SEL_NONE;
endmodule

// File: rtl/clk_irq_group.sv
`timescale 1ns/1ps
module clk_irq_group #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] evt,
  input  logic         w1cStb,
  input  logic         enStb,
  input  logic         disStb,
  input  logic [N-1:0] wd,
  output logic [N-1:0] status,
  output logic [N-1:0] mask,
  output logic         irq
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rstN) begin
        status[i] <= 1'b0;
        mask[i]   <= 1'b1;
      end else begin
        status[i] <= evt[i] | (status[i] & ~(w1cStb & wd[i]));
        if (disStb && wd[i])     mask[i] <= 1'b1;
        else if (enStb && wd[i]) mask[i] <= 1'b0;
      end
    end
  end

  assign irq = |(status & ~mask);
endmodule

// File: rtl/clk_irq_dp.sv
`timescale 1ns/1ps
module clk_irq_dp
  import clk_irq_pkg::*;
#(
  parameter int          CLK_N      = 2,
  parameter int          CAL_W      = 21,
  parameter int          TICK_W     = 16,
  parameter logic [31:0] CTRL_RESET = 32'h0100_0000,
  parameter logic [31:0] CTRL_RSVD  = 32'h70ff_fffe
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  regSel_e           rdSel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CLK_N-1:0]  evtClk,
  input  logic              evtErr,
  input  logic [DATA_W-1:0] timeIn,
  input  logic [TICK_W-1:0] tickIn,
  output logic [DATA_W-1:0] rdata,
  output logic [CLK_N-1:0]  clkStat,
  output logic [CLK_N-1:0]  clkMask,
  output logic              errStat,
  output logic              errMask,
  output logic              irqClk,
  output logic              irqErr
);
  localparam logic [DATA_W-1:0] CTRL_WMASK = ~CTRL_RSVD;

  logic [DATA_W-1:0] ctrlQ, setTQ, alarmQ, safeQ;
  logic [CAL_W-1:0]  calQ;

  clk_irq_group #(.N(CLK_N)) u_clkGrp (
    .clk(clk), .rstN(rstN), .evt(evtClk),
    .w1cStb(stb.w1cClk), .enStb(stb.enClk), .disStb(stb.disClk),
    .wd(wdata[CLK_N-1:0]), .status(clkStat), .mask(clkMask), .irq(irqClk)
  );

  clk_irq_group #(.N(1)) u_errGrp (
    .clk(clk), .rstN(rstN), .evt(evtErr | stb.badAcc),
    .w1cStb(stb.w1cErr), .enStb(stb.enErr), .disStb(stb.disErr),
    .wd(wdata[0]), .status(errStat), .mask(errMask), .irq(irqErr)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ  <= CTRL_RESET;
      setTQ  <= '0;
      calQ   <= '0;
      alarmQ <= '0;
      safeQ  <= '0;
    end else begin
      if (stb.wrCtrl)  ctrlQ  <= wdata & CTRL_WMASK;
      if (stb.wrSetT)  setTQ  <= wdata;
      if (stb.wrCal)   calQ   <= wdata[CAL_W-1:0];
      if (stb.wrAlarm) alarmQ <= wdata;
      if (stb.wrSafe)  safeQ  <= wdata;
    end
  end

  always_comb begin
    case (rdSel)
      SEL_CTRL:   rdata = ctrlQ;
      SEL_CSTAT:  rdata = DATA_W'(clkStat);
      SEL_CMASK:  rdata = DATA_W'(clkMask);
      SEL_ESTAT:  rdata = DATA_W'(errStat);
      SEL_EMASK:  rdata = DATA_W'(errMask);
      SEL_SETT,
      SEL_SETTRB: rdata = setTQ;
      SEL_CAL,
      SEL_CALRB:  rdata = DATA_W'(calQ);
      SEL_TIME:   rdata = timeIn;
      SEL_TICK:   rdata = DATA_W'(tickIn);
      SEL_ALARM:  rdata = alarmQ;
      SEL_SAFE:   rdata = safeQ;
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/clk_irq_regbank.sv
`timescale 1ns/1ps
module clk_irq_regbank
  import clk_irq_pkg::*;
#(
  parameter int          CAL_W      = 21,
  parameter int          TICK_W     = 16,
  parameter logic [31:0] CTRL_RESET = 32'h0100_0000,
  parameter logic [31:0] CTRL_RSVD  = 32'h70ff_fffe
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [7:0]        busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic [1:0]        evtClk,
  input  logic              evtErr,
  input  logic [31:0]       timeIn,
  input  logic [TICK_W-1:0] tickIn,
  output logic              irqClk,
  output logic              irqErr
);
  strobe_t    stb;
  regSel_e    rdSel;
  logic [1:0] clkStat, clkMask;
  logic       errStat, errMask;

  clk_irq_ctrl u_ctrl (
    .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
    .stb(stb), .rdSel(rdSel)
  );

  clk_irq_dp #(
    .CLK_N(2), .CAL_W(CAL_W), .TICK_W(TICK_W),
    .CTRL_RESET(CTRL_RESET), .CTRL_RSVD(CTRL_RSVD)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rdSel(rdSel), .wdata(busWdata),
    .evtClk(evtClk), .evtErr(evtErr), .timeIn(timeIn), .tickIn(tickIn),
    .rdata(busRdata), .clkStat(clkStat), .clkMask(clkMask),
    .errStat(errStat), .errMask(errMask), .irqClk(irqClk), .irqErr(irqErr)
  );
endmodule

// File: rtl/clk_irq_chk.sv
`timescale 1ns/1ps
module clk_irq_chk
  import clk_irq_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        busSel,
  input logic        busWe,
  input logic [7:0]  busAddr,
  input logic [31:0] busWdata,
  input logic [31:0] busRdata,
  input logic [1:0]  evtClk,
  input logic        irqClk,
  input logic [1:0]  clkStat,
  input logic [1:0]  clkMask,
  input logic        errStat
);
  logic unmapped;
  assign unmapped = (busAddr[1:0] != 2'b00) || (busAddr > OFF_SAFE);

  p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rstN)
    evtClk[0] |=> clkStat[0]);

  p_clear_needs_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clkStat[0]) |-> $past(busSel && busWe && busAddr == OFF_CSTAT && busWdata[0]));

  p_full_mask_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    (clkMask == 2'b11) |-> !irqClk);

  p_mask_only_by_cmd_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && busWe && (busAddr == OFF_CEN || busAddr == OFF_CDIS)) |=> $stable(clkMask));

  p_rsvd_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWe && busAddr == OFF_CTRL) |-> ((busRdata & 32'h70ff_fffe) == 32'h0));

  p_unmapped_flags_r12: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && unmapped) |=> errStat);

  p_unmapped_reads_zero_r12: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWe && unmapped) |-> (busRdata == 32'h0));
endmodule

bind clk_irq_regbank clk_irq_chk u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
  .busWdata(busWdata), .busRdata(busRdata), .evtClk(evtClk), .irqClk(irqClk),
  .clkStat(clkStat), .clkMask(clkMask), .errStat(errStat)
);

// File: tb/test_clk_irq_regbank.sv
`timescale 1ns/1ps
module test_clk_irq_regbank;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWe = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [1:0]  evtClk = '0;
  logic        evtErr = 1'b0;
  logic [31:0] timeIn = 32'h1234_5678;
  logic [15:0] tickIn = 16'hBEEF;
  logic        irqClk, irqErr;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  clk_irq_regbank i_clk_irq_regbank (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .evtClk(evtClk), .evtErr(evtErr),
    .timeIn(timeIn), .tickIn(tickIn), .irqClk(irqClk), .irqErr(irqErr)
  );

  // Reference state, kept behaviourally
  logic [31:0] mCtrl, mSetT, mCal, mAlarm, mSafe;
  logic [1:0]  mCStat, mCMask;
  logic        mEStat, mEMask;

  function automatic bit isMapped(input logic [7:0] a);
    return (a[1:0] == 2'b00) && (a <= 8'h40);
  endfunction

  function automatic logic [31:0] modelRead(input logic [7:0] a);
    case (a)
      8'h00: return mCtrl;
      8'h04: return {30'h0, mCStat};
      8'h08: return {30'h0, mCMask};
      8'h14: return {31'h0, mEStat};
      8'h18: return {31'h0, mEMask};
      8'h24, 8'h28: return mSetT;
      8'h2C, 8'h30: return mCal;
      8'h34: return timeIn;
      8'h38: return {16'h0, tickIn};
      8'h3C: return mAlarm;
      8'h40: return mSafe;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCtrl = 32'h0100_0000; mSetT = 0; mCal = 0; mAlarm = 0; mSafe = 0;
      mCStat = 2'b00; mCMask = 2'b11; mEStat = 1'b0; mEMask = 1'b1;
    end else begin
      logic [1:0] nC;
      logic       nE;
      logic       wr;
      wr = busSel && busWe;
      nC = mCStat;
      nE = mEStat;
      if (wr && busAddr == 8'h04) nC = nC & ~busWdata[1:0];
      if (wr && busAddr == 8'h14) nE = nE & ~busWdata[0];
      nC = nC | evtClk;
      nE = nE | evtErr | (busSel && !isMapped(busAddr));
      mCStat = nC;
      mEStat = nE;
      if (wr) begin
        case (busAddr)
          8'h00: mCtrl  = busWdata & 32'h8f00_0001;
          8'h0C: mCMask = mCMask & ~busWdata[1:0];
          8'h10: mCMask = mCMask | busWdata[1:0];
          8'h1C: mEMask = mEMask & ~busWdata[0];
          8'h20: mEMask = mEMask | busWdata[0];
          8'h24: mSetT  = busWdata;
          8'h2C: mCal   = busWdata & 32'h001f_ffff;
          8'h3C: mAlarm = busWdata;
          8'h40: mSafe  = busWdata;
          default: ;
        endcase
      end
    end
  end

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
    end
  endtask

  // One bus cycle; outputs compared mid-cycle against the reference
  task automatic step(input logic sel, input logic we, input logic [7:0] a,
                      input logic [31:0] wd, input logic [1:0] ec, input logic ee,
                      input string tag);
    @(negedge clk);
    busSel = sel; busWe = we; busAddr = a; busWdata = wd; evtClk = ec; evtErr = ee;
    #5;
    check("R5", "irqClk", {31'h0, irqClk}, {31'h0, |(mCStat & ~mCMask)});
    check("R5", "irqErr", {31'h0, irqErr}, {31'h0, mEStat & ~mEMask});
    if (sel && !we) check(tag, $sformatf("read @%02h", a), busRdata, modelRead(a));
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    step(1'b1, 1'b0, a, 32'h0, 2'b00, 1'b0, tag);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    step(1'b1, 1'b1, a, d, 2'b00, 1'b0, tag);
  endtask

  task automatic evt(input logic [1:0] ec, input logic ee, input string tag);
    step(1'b0, 1'b0, 8'h00, 32'h0, ec, ee, tag);
  endtask

  initial begin
    #(20 * 200000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset values
    rd(8'h00, "R1"); rd(8'h08, "R1"); rd(8'h18, "R1"); rd(8'h04, "R1"); rd(8'h14, "R1");
    // R6 direct mask writes ignored
    wr(8'h08, 32'h0, "R6"); rd(8'h08, "R6");
    wr(8'h18, 32'h0, "R6"); rd(8'h18, "R6");
    // R2 event while masked: status set, no interrupt
    evt(2'b01, 1'b0, "R2"); rd(8'h04, "R2");
    // R7 unmask bit 0 only
    wr(8'h0C, 32'h1, "R7"); rd(8'h08, "R7"); rd(8'h0C, "R7"); rd(8'h10, "R7");
    // R3 clear with zero bit then one bit
    wr(8'h04, 32'h2, "R3"); rd(8'h04, "R3");
    wr(8'h04, 32'h1, "R3"); rd(8'h04, "R3");
    // R2 bit 1 masked, then set-wins
    evt(2'b10, 1'b0, "R2"); rd(8'h04, "R2");
    step(1'b1, 1'b1, 8'h04, 32'h2, 2'b10, 1'b0, "R2"); rd(8'h04, "R2");
    wr(8'h0C, 32'h2, "R7"); rd(8'h08, "R7");
    wr(8'h10, 32'h3, "R7"); rd(8'h08, "R7");
    wr(8'h04, 32'h3, "R3"); rd(8'h04, "R3");
    // R4 error group
    evt(2'b00, 1'b1, "R4"); rd(8'h14, "R4");
    wr(8'h1C, 32'h1, "R7"); rd(8'h18, "R7"); rd(8'h1C, "R7");
    wr(8'h14, 32'h1, "R4"); rd(8'h14, "R4");
    // R12 unmapped and misaligned accesses
    rd(8'h44, "R12"); rd(8'h14, "R12");
    wr(8'h14, 32'h1, "R4");
    wr(8'h25, 32'hFFFF_FFFF, "R12"); rd(8'h24, "R12"); rd(8'h14, "R12");
    rd(8'hFC, "R12");
    wr(8'h20, 32'h1, "R7"); rd(8'h18, "R7");
    wr(8'h14, 32'h1, "R4");
    // R8 control
    wr(8'h00, 32'hFFFF_FFFF, "R8"); rd(8'h00, "R8");
    wr(8'h00, 32'h0, "R8"); rd(8'h00, "R8");
    // R9 / R10 stores and read-backs
    wr(8'h24, 32'hA5A5_0F0F, "R9"); rd(8'h24, "R9"); rd(8'h28, "R10");
    wr(8'h28, 32'h1111_1111, "R10"); rd(8'h28, "R10");
    wr(8'h2C, 32'hFFFF_FFFF, "R9"); rd(8'h2C, "R9"); rd(8'h30, "R10");
    wr(8'h30, 32'h0, "R10"); rd(8'h30, "R10");
    wr(8'h3C, 32'hDEAD_BEEF, "R9"); rd(8'h3C, "R9");
    wr(8'h40, 32'h0BAD_F00D, "R9"); rd(8'h40, "R9");
    // R11 live values
    rd(8'h34, "R11"); rd(8'h38, "R11");
    wr(8'h34, 32'h0, "R11"); wr(8'h38, 32'h0, "R11");
    timeIn = 32'h0000_0042; tickIn = 16'h8001;
    rd(8'h34, "R11"); rd(8'h38, "R11");
    evt(2'b00, 1'b0, "R5");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule